// File: doc/BRIEF.md
# Split-Transaction Response Tracker

This block sits on the initiator side of a point-to-point link where requests and responses travel on separate handshaked channels. It lets the initiator put several requests on the wire without waiting for any answer. Each accepted request is stamped with a sequence number and recorded under its thread tag. Each returning response must echo the tag of the request it answers. The tracker pairs the response with the oldest open request of that tag. It retires that entry and hands the response on together with the original sequence number.

Two checking policies exist, selected by a static mode input. In tagged mode, responses for different tags may return in any order, while responses within one tag must stay in order. In strict mode, every response must answer the oldest open request of the whole table. A response that breaks the active policy, or that names a tag with nothing open, is dropped and raises a sticky error flag. The mode may only be changed while nothing is outstanding.

Top module: `split_resp_tracker`

## Requirements
- R1: After reset the table is empty, `proto_err` and `out_valid` are 0, and the first request accepted carries `fwd_seq` 0.
- R2: The request channel passes through combinationally: `fwd_valid` = `req_valid` and room, `req_ready` = `fwd_ready` and room, `fwd_tag`/`fwd_data` equal `req_tag`/`req_data`. Each accepted request takes the next sequence number, counting up by one modulo 2^SEQ_W.
- R3: When DEPTH requests are open, `req_ready` and `fwd_valid` are held low.
- R4: With `inorder_mode` = 0, a response whose tag has an open request is accepted and appears on the output one cycle later with its tag and data and the sequence number of that request, whatever the order across tags.
- R5: Within one tag, each accepted response is paired with the oldest open request of that tag.
- R6: A response whose tag has no open request is dropped: no output, the open entries are unchanged, and `proto_err` is 1 from the next cycle.
- R7: With `inorder_mode` = 1, a response must answer the oldest open request of the whole table; any other response is dropped, the entries stay, and `proto_err` is set.
- R8: A request and a retiring response in the same cycle leave the open count unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output holds and `rsp_ready` is 0. When `out_ready` rises, a waiting response is taken in that same cycle.
- R10: `proto_err` stays 1 until reset; reset also discards every open entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inorder_mode | input | 1 | 1 = strict whole-table order, 0 = per-tag order |
| req_valid | input | 1 | Initiator request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_tag | input | TAG_W | Thread tag of the request |
| req_data | input | DATA_W | Request payload |
| fwd_valid | output | 1 | Request forwarded onto the link |
| fwd_ready | input | 1 | Link can take a request |
| fwd_tag | output | TAG_W | Forwarded tag |
| fwd_data | output | DATA_W | Forwarded payload |
| fwd_seq | output | SEQ_W | Sequence number given to this request |
| rsp_valid | input | 1 | Response valid from the link |
| rsp_ready | output | 1 | Response accepted |
| rsp_tag | input | TAG_W | Tag echoed by the response |
| rsp_data | input | DATA_W | Response payload |
| out_valid | output | 1 | Matched response available |
| out_ready | input | 1 | Consumer takes the matched response |
| out_tag | output | TAG_W | Tag of the matched response |
| out_data | output | DATA_W | Payload of the matched response |
| out_seq | output | SEQ_W | Sequence number of the request it answers |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Issuing a request and retiring a response can fall in the same cycle. The bench fills the table to DEPTH, retires one entry, and then drives a new request and a matching response on the same clock edge. It judges the result by the sequence number of the retired response and by checking that exactly one further request is accepted before `req_ready` falls. A second overlap, the release of a stalled output together with the intake of a waiting response, is provoked by raising `out_ready` while a response is held off. It is judged by the new sequence number appearing on the very next cycle.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic {
    MODE_TAGGED  = 1'b0,
    MODE_INORDER = 1'b1
  } srt_mode_e;
endpackage

// File: rtl/srt_seq_fifo.sv
module srt_seq_fifo #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             pop,
  output logic             empty,
  output logic [SEQ_W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign empty = (fill == '0);
  assign head  = mem[rd_ptr];
endmodule

// File: rtl/srt_seq_table.sv
module srt_seq_table #(
  parameter int TAG_W = 2,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             pop,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_open,
  output logic [SEQ_W-1:0] look_seq
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic             empties [NUM_TAGS];
  logic [SEQ_W-1:0] heads   [NUM_TAGS];

  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
    srt_seq_fifo #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (push && (push_tag == TAG_W'(t))),
      .push_seq (push_seq),
      .pop      (pop && (look_tag == TAG_W'(t))),
      .empty    (empties[t]),
      .head     (heads[t])
    );
  end

  assign look_open = !empties[look_tag];
  assign look_seq  = heads[look_tag];
endmodule

// File: rtl/srt_out_stage.sv
module srt_out_stage #(
  parameter int TAG_W  = 2,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SEQ_W-1:0]  in_seq,
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  output logic [SEQ_W-1:0]  out_seq
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_tag  <= in_tag;
      out_data <= in_data;
      out_seq  <= in_seq;
    end
  end
endmodule

// File: rtl/split_resp_tracker.sv
module split_resp_tracker
  import srt_pkg::*;
#(
  parameter int TAG_W  = 2,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inorder_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [DATA_W-1:0] fwd_data,
  output logic [SEQ_W-1:0]  fwd_seq,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              proto_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] open_cnt;
  logic [SEQ_W-1:0] issue_seq;
  logic [SEQ_W-1:0] expect_seq;
  logic             room;
  logic             req_fire, rsp_fire, retire, reject;
  logic             look_open;
  logic [SEQ_W-1:0] look_seq;
  logic             order_ok;
  srt_mode_e        mode;

  assign mode      = srt_mode_e'(inorder_mode);
  assign room      = open_cnt < CNT_W'(DEPTH);
  assign fwd_valid = req_valid && room;
  assign req_ready = fwd_ready && room;
  assign fwd_tag   = req_tag;
  assign fwd_data  = req_data;
  assign fwd_seq   = issue_seq;
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign order_ok = (mode == MODE_TAGGED) || (look_seq == expect_seq);
  assign retire   = rsp_fire && look_open && order_ok;
  assign reject   = rsp_fire && !(look_open && order_ok);

  srt_seq_table #(.TAG_W(TAG_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .push      (req_fire),
    .push_tag  (req_tag),
    .push_seq  (issue_seq),
    .pop       (retire),
    .look_tag  (rsp_tag),
    .look_open (look_open),
    .look_seq  (look_seq)
  );

  srt_out_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (retire),
    .in_tag    (rsp_tag),
    .in_data   (rsp_data),
    .in_seq    (look_seq),
    .can_take  (rsp_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .out_data  (out_data),
    .out_seq   (out_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      open_cnt   <= '0;
      issue_seq  <= '0;
      expect_seq <= '0;
      proto_err  <= 1'b0;
    end else begin
      open_cnt <= open_cnt + CNT_W'(req_fire) - CNT_W'(retire);
      if (req_fire) issue_seq <= issue_seq + 1'b1;
      if (open_cnt == '0) expect_seq <= issue_seq;
      else if (retire && mode == MODE_INORDER) expect_seq <= expect_seq + 1'b1;
      if (reject) proto_err <= 1'b1;
    end
  end
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             fwd_valid,
  input logic             rsp_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SEQ_W-1:0] out_seq,
  input logic [SEQ_W-1:0] fwd_seq,
  input logic [CNT_W-1:0] open_cnt,
  input logic             proto_err
);
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (open_cnt == CNT_W'(DEPTH)) |-> (!req_ready && !fwd_valid)) else $error("full stall"); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    open_cnt <= CNT_W'(DEPTH)) else $error("count bound"); // R3
  AST_FWD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> req_valid) else $error("fwd without req"); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (fwd_seq == $past(fwd_seq) + 1'b1)) else $error("seq step"); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seq))) else $error("out hold"); // R9
  AST_RSP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !rsp_ready) else $error("rsp block"); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err) else $error("err sticky"); // R10
endmodule

bind split_resp_tracker srt_checker #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W($clog2(DEPTH + 1))
) u_srt_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .fwd_valid (fwd_valid),
  .rsp_ready (rsp_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_seq   (out_seq),
  .fwd_seq   (fwd_seq),
  .open_cnt  (open_cnt),
  .proto_err (proto_err)
);

// File: tb/split_resp_tracker_bench.sv
`timescale 1ns/1ps
module split_resp_tracker_bench;
  localparam int TAG_W = 2, DATA_W = 32, DEPTH = 8, SEQ_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inorder_mode = 1'b0;
  logic req_valid = 1'b0, fwd_ready = 1'b1, rsp_valid = 1'b0, out_ready = 1'b1;
  logic [TAG_W-1:0] req_tag = '0, rsp_tag = '0;
  logic [DATA_W-1:0] req_data = '0, rsp_data = '0;
  logic req_ready, fwd_valid, rsp_ready, out_valid, proto_err;
  logic [TAG_W-1:0] fwd_tag, out_tag;
  logic [DATA_W-1:0] fwd_data, out_data;
  logic [SEQ_W-1:0] fwd_seq, out_seq;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  split_resp_tracker #(.TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W))
  u_split_resp_tracker (
    .clk(clk), .rst(rst), .inorder_mode(inorder_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_data(req_data),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_tag(fwd_tag), .fwd_data(fwd_data),
    .fwd_seq(fwd_seq),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
    .out_seq(out_seq), .proto_err(proto_err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0; rsp_valid = 1'b0; out_ready = 1'b1; fwd_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one request, check its forwarded fields and sequence number
  task automatic send_req(input int tag, input int data, input int exp_seq, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_tag = TAG_W'(tag); req_data = DATA_W'(data);
    #0.5;
    while (!req_ready) begin
      @(negedge clk); #0.5;
    end
    chk(req, "fwd_valid", fwd_valid, 1);
    chk(req, "fwd_seq", fwd_seq, exp_seq);
    chk(req, "fwd_tag", fwd_tag, tag);
    chk(req, "fwd_data", fwd_data, data);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // drive one response, then judge the output one cycle later
  task automatic send_rsp(input int tag, input int data, input bit ok, input int exp_seq,
                          input string req);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = TAG_W'(tag); rsp_data = DATA_W'(data);
    #0.5;
    while (!rsp_ready) begin
      @(negedge clk); #0.5;
    end
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(req, "out_valid", out_valid, ok);
    if (ok) begin
      chk(req, "out_seq", out_seq, exp_seq);
      chk(req, "out_tag", out_tag, tag);
      chk(req, "out_data", out_data, data);
    end else begin
      chk(req, "proto_err", proto_err, 1);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #0.5;
    chk("R1", "proto_err", proto_err, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
    fwd_ready = 1'b0; req_valid = 1'b1; #0.5;
    chk("R2", "req_ready with fwd_ready low", req_ready, 0);
    req_valid = 1'b0; fwd_ready = 1'b1;
  endtask

  task automatic t_tagged();
    do_reset(); inorder_mode = 1'b0;
    send_req(0, 'h100, 0, "R1");
    send_req(1, 'h101, 1, "R2");
    send_req(0, 'h102, 2, "R2");
    send_req(2, 'h103, 3, "R2");
    send_rsp(1, 'hA1, 1, 1, "R4");
    send_rsp(0, 'hA0, 1, 0, "R5");
    send_rsp(2, 'hA2, 1, 3, "R4");
    send_rsp(0, 'hA3, 1, 2, "R5");
    chk("R4", "proto_err", proto_err, 0);
  endtask

  task automatic t_unknown();
    do_reset(); inorder_mode = 1'b0;
    send_req(0, 'h7, 0, "R1");
    send_rsp(3, 'hBAD, 0, 0, "R6");
    send_rsp(0, 'h55, 1, 0, "R6");
    chk("R10", "proto_err sticky", proto_err, 1);
    send_req(1, 'h8, 1, "R2");
    do_reset(); #0.5;
    chk("R10", "proto_err after reset", proto_err, 0);
    send_rsp(1, 'h9, 0, 0, "R10");
    do_reset();
    send_req(2, 'h1, 0, "R1");
  endtask

  task automatic t_inorder();
    do_reset(); inorder_mode = 1'b1;
    send_req(1, 'h11, 0, "R2");
    send_req(2, 'h12, 1, "R2");
    send_rsp(2, 'hC2, 0, 0, "R7");
    send_rsp(1, 'hC1, 1, 0, "R7");
    send_rsp(2, 'hC3, 1, 1, "R7");
    chk("R10", "proto_err sticky", proto_err, 1);
    do_reset(); inorder_mode = 1'b0;
  endtask

  task automatic t_full();
    do_reset(); inorder_mode = 1'b0;
    for (int i = 0; i < DEPTH; i++) send_req(0, 'h200 + i, i, "R2");
    @(negedge clk); req_valid = 1'b1; req_tag = 1; #0.5;
    chk("R3", "req_ready when full", req_ready, 0);
    chk("R3", "fwd_valid when full", fwd_valid, 0);
    req_valid = 1'b0;
    send_rsp(0, 'hD0, 1, 0, "R5");
    // request and retire on the same edge
    @(negedge clk);
    req_valid = 1'b1; req_tag = 1; req_data = 'h300;
    rsp_valid = 1'b1; rsp_tag = 0; rsp_data = 'hD1;
    #0.5;
    chk("R8", "req_ready", req_ready, 1);
    chk("R8", "fwd_seq", fwd_seq, 8);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    chk("R8", "out_seq", out_seq, 1);
    send_req(2, 'h301, 9, "R8");
    @(negedge clk); req_valid = 1'b1; req_tag = 3; #0.5;
    chk("R8", "req_ready after refill", req_ready, 0);
    req_valid = 1'b0;
    send_rsp(2, 'hE2, 1, 9, "R4");
    send_rsp(1, 'hE1, 1, 8, "R4");
    for (int i = 2; i < DEPTH; i++) send_rsp(0, 'hF0 + i, 1, i, "R5");
    chk("R8", "proto_err", proto_err, 0);
  endtask

  task automatic t_backpressure();
    do_reset(); inorder_mode = 1'b0;
    send_req(3, 'h40, 0, "R2");
    send_req(3, 'h41, 1, "R2");
    @(negedge clk); out_ready = 1'b0;
    send_rsp(3, 'h90, 1, 0, "R9");
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = 3; rsp_data = 'h91; #0.5;
    chk("R9", "rsp_ready while held", rsp_ready, 0);
    repeat (2) @(negedge clk);
    chk("R9", "out_valid held", out_valid, 1);
    chk("R9", "out_seq held", out_seq, 0);
    chk("R9", "out_data held", out_data, 'h90);
    out_ready = 1'b1; #0.5;
    chk("R9", "rsp_ready on release", rsp_ready, 1);
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R9", "out_valid after swap", out_valid, 1);
    chk("R9", "out_seq after swap", out_seq, 1);
    @(negedge clk);
    chk("R9", "out_valid drained", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_tagged();
    t_unknown();
    t_inorder();
    t_full();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule